// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetch Unit

This unit sits between a set of interrupt request lines and a word-addressed program memory. It chooses one request at a time and retrieves that request's 22-bit service-routine start address from a table in memory. There are fifteen sources: a reset request that cannot be masked and fourteen maskable lines. A maskable line competes only when its pending bit, its own enable bit and the global enable are all set. Reset beats every maskable line. Among the maskable lines, the lower line number wins.

The unit retrieves a winner's address with two single-word reads on a simple request/valid memory port. It reads the even word first and then the odd word. The even word gives address bits 15:0. The six low bits of the odd word give bits 21:16, and the unit drops the rest of that word. The table holds one two-word slot per source, at `base + 2*slot`. A map register picks the base: 0x3FFFC0 when the register is 1 and 0x000000 when it is 0. The register is 1 after reset and can be rewritten through a write strobe.

When the second word arrives, the unit presents the vector with a one-cycle valid pulse. In the same cycle it gives a one-hot acknowledge so that the requester can clear its pending bit.

Top module: `irq_vec_fetch`

## Requirements
- R1: While rst_ni is low, vec_valid_o, rd_req_o and every bit of ack_o are 0.
- R2: Once reset is released, the first fetch is for slot 0 (reset), and its ack_o has bit 0 set. This holds even when maskable lines are pending and enabled.
- R3: Line k (k = 1..14) takes part in arbitration only when pend_i[k-1], en_i[k-1] and glob_en_i are all 1. If no source qualifies, the unit issues no read.
- R4: The order of priority is reset (slot 0) first, then INT1 (slot 1), and so on down to INT14 (slot 14). The qualifying source with the lowest slot number is served.
- R5: The even read address of slot n is base + 2n. The base is 0x3FFFC0 when the map register is 1 and 0x000000 when it is 0. The register is 1 after reset and loads map_sel_i on any cycle with map_we_i high.
- R6: Each fetch makes exactly two reads, each with a one-cycle rd_req_o. The first read is at the even address and the second at the even address + 1. The second read is issued only after rd_valid_i has returned for the first.
- R7: vec_o[15:0] is the even word. vec_o[21:16] is bits 5:0 of the odd word. Bits 15:6 of the odd word have no effect on the vector.
- R8: vec_valid_o is high for exactly one cycle per fetch. In that cycle ack_o is one-hot: bit 0 stands for reset and bit k for INTk. Outside that cycle ack_o is 0.
- R9: The winner and the table base are captured when a fetch starts. Changes to pending lines or the map register during the fetch do not affect the vector or acknowledge being produced.
- R10: Only slots 0..14 are ever addressed. Slots 15..31 of the table are never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_we_i | input | 1 | Write strobe for the map register |
| map_sel_i | input | 1 | New map register value (1 = high base) |
| glob_en_i | input | 1 | Global enable for the maskable lines |
| pend_i | input | 14 | Pending bits; bit k-1 is INTk |
| en_i | input | 14 | Per-line enables; bit k-1 is INTk |
| rd_req_o | output | 1 | One-cycle memory read request |
| rd_addr_o | output | 22 | Word address of the read |
| rd_data_i | input | 16 | Read data |
| rd_valid_i | input | 1 | Read data valid |
| vec_valid_o | output | 1 | Vector valid pulse |
| vec_o | output | 22 | Assembled service-routine address |
| ack_o | output | 15 | One-hot acknowledge; bit 0 reset, bit k INTk |

## Verification
Two things can happen at the same moment: a fetch that is already running and a new request (or a change of the map register) that would win if arbitration were done again. The bench starts a fetch for a low-priority line and slows the memory down. Once the even-word request has been seen, it raises INT1 and clears the map register. The fetch in flight must still finish with the original line's acknowledge and a vector from the old base. The very next fetch must then serve INT1 from the new base.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W    = 22;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned VEC_W     = 22;
  localparam int unsigned NUM_LINES = 14;
  localparam int unsigned NUM_SRC   = NUM_LINES + 1;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] BASE_LO = 22'h000000;
  localparam logic [ADDR_W-1:0] BASE_HI = 22'h3FFFC0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISS_LO,
    ST_WAIT_LO,
    ST_ISS_HI,
    ST_WAIT_HI,
    ST_DONE
  } fetch_state_e;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N     = 15,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N-1:0] higher;

  // higher[i]: some source with a smaller index is requesting
  assign higher[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign higher[i] = higher[i-1] | req_i[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign gnt_o[i] = req_i[i] & ~higher[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned IDX_W  = 4,
  parameter logic [ADDR_W-1:0] BASE_LO = '0,
  parameter logic [ADDR_W-1:0] BASE_HI = '0
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              map_hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign base   = map_hi_i ? BASE_HI : BASE_LO;
  assign offs   = ADDR_W'(idx_i) << 1;
  assign addr_o = base + offs;
endmodule

// File: rtl/irq_fetch_ctrl.sv
module irq_fetch_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned D_W = DATA_W,
  parameter int unsigned V_W = VEC_W,
  parameter int unsigned N   = NUM_SRC
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   gnt_i,
  input  logic [A_W-1:0] addr_i,
  output logic           rd_req_o,
  output logic [A_W-1:0] rd_addr_o,
  input  logic [D_W-1:0] rd_data_i,
  input  logic           rd_valid_i,
  output logic           vec_valid_o,
  output logic [V_W-1:0] vec_o,
  output logic [N-1:0]   ack_o
);
  localparam int unsigned HI_W = V_W - D_W;

  fetch_state_e   state_q;
  logic [N-1:0]   gnt_q;
  logic [A_W-1:0] addr_q;
  logic [D_W-1:0] lo_q;
  logic [V_W-1:0] vec_q;
  logic           unused_hi;

  assign unused_hi = ^rd_data_i[D_W-1:HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            gnt_q   <= gnt_i;
            addr_q  <= addr_i;
            state_q <= ST_ISS_LO;
          end
        end
        ST_ISS_LO:  state_q <= ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (rd_valid_i) begin
            lo_q    <= rd_data_i;
            state_q <= ST_ISS_HI;
          end
        end
        ST_ISS_HI:  state_q <= ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (rd_valid_i) begin
            vec_q   <= {rd_data_i[HI_W-1:0], lo_q};
            state_q <= ST_DONE;
          end
        end
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o    = (state_q == ST_ISS_LO) || (state_q == ST_ISS_HI);
  assign rd_addr_o   = (state_q == ST_ISS_HI) ? (addr_q | A_W'(1)) : addr_q;
  assign vec_valid_o = (state_q == ST_DONE);
  assign vec_o       = vec_q;
  assign ack_o       = vec_valid_o ? gnt_q : '0;
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
  import irq_vec_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 map_we_i,
  input  logic                 map_sel_i,
  input  logic                 glob_en_i,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] en_i,
  output logic                 rd_req_o,
  output logic [ADDR_W-1:0]    rd_addr_o,
  input  logic [DATA_W-1:0]    rd_data_i,
  input  logic                 rd_valid_i,
  output logic                 vec_valid_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [NUM_SRC-1:0]   ack_o
);
  logic               map_hi_q;
  logic               rst_pend_q;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] gnt;
  logic [IDX_W-1:0]   idx;
  logic               any;
  logic [ADDR_W-1:0]  slot_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_hi_q <= 1'b1;
    else if (map_we_i) map_hi_q <= map_sel_i;
  end

  // reset vector owed until its fetch completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pend_q <= 1'b1;
    else if (ack_o[0]) rst_pend_q <= 1'b0;
  end

  assign req[0] = rst_pend_q;
  for (genvar k = 1; k < NUM_SRC; k++) begin : g_req
    assign req[k] = pend_i[k-1] & en_i[k-1] & glob_en_i;
  end

  irq_prio_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i (req),
    .gnt_o (gnt),
    .idx_o (idx),
    .any_o (any)
  );

  irq_vec_addr #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .BASE_LO(BASE_LO),
    .BASE_HI(BASE_HI)
  ) u_addr (
    .idx_i   (idx),
    .map_hi_i(map_hi_q),
    .addr_o  (slot_addr)
  );

  irq_fetch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (any),
    .gnt_i      (gnt),
    .addr_i     (slot_addr),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .rd_valid_i (rd_valid_i),
    .vec_valid_o(vec_valid_o),
    .vec_o      (vec_o),
    .ack_o      (ack_o)
  );
endmodule

// File: rtl/irq_vec_fetch_chk.sv
module irq_vec_fetch_chk
  import irq_vec_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_req_o,
  input logic [ADDR_W-1:0]   rd_addr_o,
  input logic                rd_valid_i,
  input logic                vec_valid_o,
  input logic [NUM_SRC-1:0]  ack_o
);
  logic out_q;
  logic seen_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q      <= 1'b0;
      seen_rst_q <= 1'b0;
    end else begin
      if (rd_req_o) out_q <= 1'b1;
      else if (rd_valid_i) out_q <= 1'b0;
      if (vec_valid_o && ack_o[0]) seen_rst_q <= 1'b1;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $countones(ack_o) == 1); // R8
  AST_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> ack_o == '0); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o); // R8
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !out_q); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> ((rd_addr_o[ADDR_W-1:6] == '0) || (&rd_addr_o[ADDR_W-1:6]))
                 && (rd_addr_o[5:0] <= 6'd29)); // R10
  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !seen_rst_q) |-> ack_o[0]); // R2
endmodule

bind irq_vec_fetch irq_vec_fetch_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .vec_valid_o(vec_valid_o),
  .ack_o      (ack_o)
);

// File: tb/irq_vec_fetch_tb_top.sv
module irq_vec_fetch_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        map_we_i = 1'b0;
  logic        map_sel_i = 1'b0;
  logic        glob_en_i = 1'b0;
  logic [13:0] pend_i = '0;
  logic [13:0] en_i = '0;
  logic        rd_req_o;
  logic [21:0] rd_addr_o;
  logic [15:0] rd_data_i = '0;
  logic        rd_valid_i = 1'b0;
  logic        vec_valid_o;
  logic [21:0] vec_o;
  logic [14:0] ack_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  irq_vec_fetch dut_i (.*);

  // memory model: word at a reads a[15:0] ^ A5C3, so the odd word has upper bits set
  function automatic logic [15:0] mem_word(logic [21:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [21:0] slot_lo(int slot, logic map_hi);
    logic [21:0] b;
    b = map_hi ? 22'h3FFFC0 : 22'h000000;
    return b + 22'(2 * slot);
  endfunction

  function automatic logic [21:0] exp_vec(int slot, logic map_hi);
    logic [21:0] lo;
    logic [15:0] hw;
    lo = slot_lo(slot, map_hi);
    hw = mem_word(lo + 22'd1);
    return {hw[5:0], mem_word(lo)};
  endfunction

  logic        mem_busy = 1'b0;
  int          mem_cnt = 0;
  int          mem_lat = 0;
  logic [21:0] mem_a = '0;
  int          nreq = 0;
  int          ovl = 0;
  logic [21:0] a0 = '0, a1 = '0;

  always @(posedge clk_i) begin
    cyc++;
    rd_valid_i <= 1'b0;
    if (mem_busy) begin
      if (mem_cnt == 0) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem_word(mem_a);
        mem_busy   <= 1'b0;
      end else mem_cnt <= mem_cnt - 1;
    end
    if (rst_ni && rd_req_o) begin
      if (mem_busy) ovl++;
      if (nreq == 0) a0 = rd_addr_o;
      else if (nreq == 1) a1 = rd_addr_o;
      nreq++;
      mem_busy <= 1'b1;
      mem_cnt  <= mem_lat;
      mem_a    <= rd_addr_o;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // waits for the vector pulse; callers clear nreq before the fetch begins
  task automatic run_fetch(input int slot, input logic map_hi, input string rq);
    int n = 0;
    logic [14:0] exp_ack;
    exp_ack = 15'(1) << slot;
    while (!vec_valid_o && n < 400) begin
      @(negedge clk_i);
      n++;
    end
    chk(vec_valid_o == 1'b1, {rq, " vec_valid"}, 64'(vec_valid_o), 64'd1);
    chk(ack_o == exp_ack, {rq, " R4 R8 ack"}, 64'(ack_o), 64'(exp_ack));
    chk(vec_o == exp_vec(slot, map_hi), {rq, " R7 vector"}, 64'(vec_o), 64'(exp_vec(slot, map_hi)));
    chk(a0 == slot_lo(slot, map_hi), {rq, " R5 even addr"}, 64'(a0), 64'(slot_lo(slot, map_hi)));
    chk(nreq == 2 && a1 == a0 + 22'd1, {rq, " R6 odd read"}, 64'(a1), 64'(a0 + 22'd1));
    chk(ovl == 0, {rq, " R6 overlap"}, 64'(ovl), 64'd0);
    pend_i = '0;
    @(negedge clk_i);
    chk(vec_valid_o == 1'b0 && ack_o == '0, {rq, " R8 pulse"}, 64'(ack_o), 64'd0);
  endtask

  typedef struct packed {
    logic        ge;
    logic [13:0] en;
    logic [13:0] pend;
    logic        map_hi;
    logic [1:0]  lat;
    logic [4:0]  slot;   // 31: no fetch expected
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 14'h3FFF, 14'h0100, 1'b1, 2'd0, 5'd9},
    '{1'b1, 14'h3FFF, 14'h2001, 1'b1, 2'd1, 5'd1},
    '{1'b0, 14'h3FFF, 14'h0004, 1'b1, 2'd0, 5'd31},
    '{1'b1, 14'h3FFB, 14'h0014, 1'b0, 2'd0, 5'd5},
    '{1'b1, 14'h3FFF, 14'h2000, 1'b0, 2'd3, 5'd14},
    '{1'b1, 14'h0000, 14'h3FFF, 1'b0, 2'd0, 5'd31},
    '{1'b1, 14'h3FFF, 14'h0060, 1'b1, 2'd2, 5'd6},
    '{1'b1, 14'h3FFF, 14'h3FFF, 1'b1, 2'd1, 5'd1}
  };

  task automatic reset_checks();
    repeat (3) begin
      @(negedge clk_i);
      chk(!vec_valid_o && !rd_req_o && ack_o == '0, "R1 reset outputs", 64'(ack_o), 64'd0);
    end
  endtask

  initial begin
    logic cur_map;
    cur_map = 1'b1;
    reset_checks();
    glob_en_i = 1'b1; en_i = '1; pend_i = '1;
    nreq = 0;
    rst_ni = 1'b1;
    run_fetch(0, 1'b1, "R2 reset first");

    foreach (TBL[i]) begin
      nreq = 0;
      mem_lat = int'(TBL[i].lat);
      if (TBL[i].map_hi != cur_map) begin
        map_sel_i = TBL[i].map_hi; map_we_i = 1'b1;
        @(negedge clk_i);
        map_we_i = 1'b0;
        cur_map = TBL[i].map_hi;
      end
      glob_en_i = TBL[i].ge; en_i = TBL[i].en; pend_i = TBL[i].pend;
      if (TBL[i].slot == 5'd31) begin
        repeat (30) @(negedge clk_i);
        chk(nreq == 0, "R3 masked no read", 64'(nreq), 64'd0);
        pend_i = '0;
      end else begin
        run_fetch(int'(TBL[i].slot), cur_map, "R3 R4 table");
      end
    end

    // R9: late higher request and map change during a slow fetch
    nreq = 0; mem_lat = 3; en_i = '1; glob_en_i = 1'b1;
    pend_i = 14'h0100;
    while (nreq == 0) @(negedge clk_i);
    pend_i = 14'h0101;
    map_sel_i = 1'b0; map_we_i = 1'b1;
    @(negedge clk_i);
    map_we_i = 1'b0;
    run_fetch(9, cur_map, "R9 frozen select");
    nreq = 0;
    pend_i = 14'h0001;
    run_fetch(1, 1'b0, "R9 next uses new map");

    // R5: map register back to high base after reset; R2 again under full load
    rst_ni = 1'b0;
    reset_checks();
    mem_lat = 0; pend_i = '1; nreq = 0;
    rst_ni = 1'b1;
    run_fetch(0, 1'b1, "R5 R2 map reset");
    nreq = 0;
    pend_i = 14'h0002;
    run_fetch(2, 1'b1, "R5 high base");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule